// File: doc/BRIEF.md
# Platform Sleep-State Sequencer

This block is the power-management controller of a platform. It moves the platform between the working state S0 and the sleep states S1, S3, S4 and S5. Software asks for a sleep level with a one-cycle request that carries a three-bit level code. The controller first stops the processor clock, then runs the handshakes that the chosen level needs, and only then drives the sleep outputs. While the platform sleeps, the platform reset is held asserted. A per-level set of wake sources brings the platform back to S0.

The raw power-button input is synchronised and debounced. A press wakes the platform from any sleep level. A short press in the working state raises a sticky status bit for software. Holding the button past the override time forces S5 from any state, including the middle of an entry sequence, and no handshake is run. Each handshake wait has a timeout. If an acknowledge never arrives, the controller aborts to S0 and sets a sticky error bit.

Top module: `pwr_state_seq`

## Requirements
- R1: After reset the controller is in S0 (`cur_state_o` = 0). Every control output and both status bits are low.
- R2: In S0, a request whose level code is not 1, 3, 4 or 5 is rejected. This covers code 2 (S2), code 0 and codes 6 and 7. The controller stays in S0 and `clkstop_req_o` stays low.
- R3: An accepted request first raises `clkstop_req_o` and then waits for `clkstop_ack_i`. No sleep output (`cpu_sleep_o`, `rail_s3_off_o`, `rail_s4_off_o`, `plat_rst_o`) and no `mem_sr_req_o` rises before the acknowledge. `clkstop_req_o` stays high in every sleep level.
- R4: S3 entry is ordered. `mem_sr_req_o` rises only in the cycle after the clock-stop acknowledge. `rail_s3_off_o` rises only in the cycle after `mem_sr_done_i` is seen while self-refresh is requested.
- R5: In S3 (`cur_state_o` = 3), `rail_s3_off_o` is high. This output also switches the memory supply to the standby source. `mem_sr_req_o` and `plat_rst_o` are also high, and `rail_s4_off_o` is low.
- R6: In S1 (`cur_state_o` = 1), `cpu_sleep_o` and `plat_rst_o` are high, and both rail outputs are low.
- R7: In S4 and S5 (`cur_state_o` = 4 or 5), `rail_s4_off_o`, `rail_s3_off_o` and `plat_rst_o` are all high.
- R8: In S1, a high level on `wake_pme_i` or `wake_pcie_i` returns the platform to S0. `wake_usb_i`, `wake_ps2_i` and `wake_lan_i` have no effect.
- R9: A debounced button press wakes the platform from every sleep level. S3 also wakes on `wake_pme_i` or `wake_pcie_i`. In S4 and S5 the button is the only wake source.
- R10: A button held for `HOLD_CYC` debounced cycles moves the controller to S5. This happens from any state, including an unfinished entry sequence, and it does not set `err_o`.
- R11: Releasing a press shorter than the override time sets the sticky `btn_short_o` without changing the state. A press that reached the override does not set it. `status_clr_i` clears both status bits.
- R12: If `clkstop_ack_i` or `mem_sr_done_i` is missing for `ACK_LIMIT` cycles of a wait, the controller returns to S0, drops all outputs and sets the sticky `err_o`.
- R13: Software requests are ignored in every state other than S0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req_valid_i | input | 1 | One-cycle software sleep request |
| sw_req_state_i | input | 3 | Requested level code (1, 3, 4, 5 valid) |
| status_clr_i | input | 1 | Clears both sticky status bits |
| pwr_btn_n_i | input | 1 | Raw power button, low when pressed |
| clkstop_ack_i | input | 1 | Processor stop-grant acknowledge |
| mem_sr_done_i | input | 1 | Memory controller reports self-refresh entered |
| wake_pme_i | input | 1 | PCI PME# wake request (active high here) |
| wake_pcie_i | input | 1 | PCI Express wake request |
| wake_usb_i | input | 1 | USB wake request (never honoured) |
| wake_ps2_i | input | 1 | PS/2 wake request (never honoured) |
| wake_lan_i | input | 1 | LAN wake request (never honoured) |
| clkstop_req_o | output | 1 | Stop-clock request to the processors |
| mem_sr_req_o | output | 1 | Self-refresh request to the memory controller |
| cpu_sleep_o | output | 1 | Processor sleep signal (S1) |
| rail_s3_off_o | output | 1 | Main rails off, memory on standby supply |
| rail_s4_off_o | output | 1 | Main supply off, auxiliary kept |
| plat_rst_o | output | 1 | Platform reset, high while asleep |
| cur_state_o | output | 3 | Settled level: 0, 1, 3, 4 or 5 |
| btn_short_o | output | 1 | Sticky short-press status |
| err_o | output | 1 | Sticky handshake-timeout status |

## Verification
All outputs are decoded from the state register. A request, an acknowledge or a wake input sampled at one rising edge therefore shows on the outputs right after that edge. The bench drives on falling edges and checks one falling edge later. A button event first passes two synchroniser flops and `DEB_CYC` debounce cycles, so about `DEB_CYC`+3 cycles elapse before it acts. The bench therefore checks button effects only after a margin of twelve cycles. The override and timeout windows are checked on both sides: once well before `HOLD_CYC` or `ACK_LIMIT` has elapsed, where nothing may have changed, and once after a few cycles of margin past the limit.

// File: rtl/pss_pkg.sv
// Shared types for the sleep-state sequencer.
// Assumes: level codes are the ACPI sleep numbers on three bits.
package pss_pkg;

    typedef enum logic [2:0] {
        PS_S0,
        PS_CLKSTOP,
        PS_SELFREF,
        PS_S1,
        PS_S3,
        PS_S4,
        PS_S5
    } pss_state_e;

    localparam logic [2:0] LVL_S0 = 3'd0;
    localparam logic [2:0] LVL_S1 = 3'd1;
    localparam logic [2:0] LVL_S3 = 3'd3;
    localparam logic [2:0] LVL_S4 = 3'd4;
    localparam logic [2:0] LVL_S5 = 3'd5;

    // True for the level codes that software may request.
    function automatic logic lvl_supported(logic [2:0] code);
        return (code == LVL_S1) || (code == LVL_S3) ||
               (code == LVL_S4) || (code == LVL_S5);
    endfunction

    // Settled level reported for a state; transitional states report S0.
    function automatic logic [2:0] lvl_of(pss_state_e s);
        case (s)
            PS_S1:   return LVL_S1;
            PS_S3:   return LVL_S3;
            PS_S4:   return LVL_S4;
            PS_S5:   return LVL_S5;
            default: return LVL_S0;
        endcase
    endfunction

endpackage

// File: rtl/pss_button.sv
// Power-button conditioner: two-flop synchroniser, debounce, hold timer.
// press_o pulses once when a debounced press starts. hold_o pulses once
// when the press has lasted HOLD_CYC cycles. short_o pulses on the release
// of a press that never reached hold_o.
// Assumes: btn_n_i is asynchronous and low while pressed; DEB_CYC >= 1.
module pss_button #(
    parameter int DEB_CYC  = 16,
    parameter int HOLD_CYC = 400_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_i,
    output logic press_o,
    output logic hold_o,
    output logic short_o
);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_CYC - 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    logic [1:0]    sync_q;
    logic          raw_pressed;
    logic [DW-1:0] deb_cnt_q;
    logic          deb_q;
    logic          prev_q;
    logic [HW-1:0] hold_cnt_q;
    logic          held_q;

    assign raw_pressed = ~sync_q[1];

    // Bring the raw button into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], btn_n_i};
    end

    // Accept a new level only after it has been stable for DEB_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb_cnt_q <= '0;
            deb_q     <= 1'b0;
        end else if (raw_pressed == deb_q) begin
            deb_cnt_q <= '0;
        end else if (deb_cnt_q == DEB_LAST) begin
            deb_cnt_q <= '0;
            deb_q     <= raw_pressed;
        end else begin
            deb_cnt_q <= deb_cnt_q + 1'b1;
        end
    end

    // Keep last debounced level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= deb_q;
    end

    // Measure the press length and remember when the override was reached.
    always_ff @(posedge clk) begin
        if (!rst_n || !deb_q) begin
            hold_cnt_q <= '0;
            held_q     <= 1'b0;
        end else if (!held_q) begin
            if (hold_cnt_q == HOLD_LAST) held_q <= 1'b1;
            else                         hold_cnt_q <= hold_cnt_q + 1'b1;
        end
    end

    assign press_o = deb_q & ~prev_q;
    assign hold_o  = deb_q & ~held_q & (hold_cnt_q == HOLD_LAST);
    assign short_o = ~deb_q & prev_q & ~held_q;

endmodule

// File: rtl/pss_ack_timer.sv
// Handshake watchdog: counts cycles while a wait is active and flags
// expiry on the LIMIT-th cycle of one wait.
// Assumes: restart_i pulses on every state change so each wait starts at 0.
module pss_ack_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles of the current wait; clear between waits.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i || !active_i) cnt_q <= '0;
        else if (cnt_q != LAST)              cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = active_i & (cnt_q == LAST);

endmodule

// File: rtl/pss_wake_gate.sv
// Per-level wake filter. S1 and S3 accept the button, PME# and PCI Express
// wake; S4 and S5 accept the button only; USB, PS/2 and LAN never wake.
// Assumes: lvl_i is the settled level, 0 while awake or in transition.
module pss_wake_gate (
    input  logic [2:0] lvl_i,
    input  logic       press_i,
    input  logic       pme_i,
    input  logic       pcie_i,
    input  logic       usb_i,
    input  logic       ps2_i,
    input  logic       lan_i,
    output logic       wake_o
);
    import pss_pkg::*;

    logic unused_wake;
    assign unused_wake = usb_i ^ ps2_i ^ lan_i;

    // Select the wake sources that are live in the current level.
    always_comb begin
        case (lvl_i)
            LVL_S1, LVL_S3: wake_o = press_i | pme_i | pcie_i;
            LVL_S4, LVL_S5: wake_o = press_i;
            default:        wake_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_state_seq.sv
// Sleep-state sequencer top. Accepts software level requests in S0, runs
// clock-stop and (for S3) self-refresh handshakes, decodes the sleep outputs
// from the state, applies wake sources and the button override, and keeps
// sticky status for short presses and handshake timeouts.
// Assumes: all inputs except the button are synchronous to clk.
module pwr_state_seq #(
    parameter int DEB_CYC   = 16,
    parameter int HOLD_CYC  = 400_000_000,
    parameter int ACK_LIMIT = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req_valid_i,
    input  logic [2:0] sw_req_state_i,
    input  logic       status_clr_i,
    input  logic       pwr_btn_n_i,
    input  logic       clkstop_ack_i,
    input  logic       mem_sr_done_i,
    input  logic       wake_pme_i,
    input  logic       wake_pcie_i,
    input  logic       wake_usb_i,
    input  logic       wake_ps2_i,
    input  logic       wake_lan_i,
    output logic       clkstop_req_o,
    output logic       mem_sr_req_o,
    output logic       cpu_sleep_o,
    output logic       rail_s3_off_o,
    output logic       rail_s4_off_o,
    output logic       plat_rst_o,
    output logic [2:0] cur_state_o,
    output logic       btn_short_o,
    output logic       err_o
);
    import pss_pkg::*;

    pss_state_e state_q, state_d;
    logic [2:0] tgt_q, tgt_d;
    logic       btn_press, btn_hold, btn_short;
    logic       waiting, ack_seen, expired, wake, abort;

    pss_button #(.DEB_CYC(DEB_CYC), .HOLD_CYC(HOLD_CYC)) button_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_n_i (pwr_btn_n_i),
        .press_o (btn_press),
        .hold_o  (btn_hold),
        .short_o (btn_short)
    );

    assign waiting  = (state_q == PS_CLKSTOP) || (state_q == PS_SELFREF);
    assign ack_seen = ((state_q == PS_CLKSTOP) && clkstop_ack_i) ||
                      ((state_q == PS_SELFREF) && mem_sr_done_i);

    pss_ack_timer #(.LIMIT(ACK_LIMIT)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (waiting),
        .restart_i (state_d != state_q),
        .expired_o (expired)
    );

    pss_wake_gate wake_i (
        .lvl_i   (cur_state_o),
        .press_i (btn_press),
        .pme_i   (wake_pme_i),
        .pcie_i  (wake_pcie_i),
        .usb_i   (wake_usb_i),
        .ps2_i   (wake_ps2_i),
        .lan_i   (wake_lan_i),
        .wake_o  (wake)
    );

    assign abort = waiting & expired & ~ack_seen & ~btn_hold;

    // Next-state selection; the button override has the last word.
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        case (state_q)
            PS_S0: begin
                if (sw_req_valid_i && lvl_supported(sw_req_state_i)) begin
                    state_d = PS_CLKSTOP;
                    tgt_d   = sw_req_state_i;
                end
            end
            PS_CLKSTOP: begin
                if (clkstop_ack_i) begin
                    case (tgt_q)
                        LVL_S1:  state_d = PS_S1;
                        LVL_S3:  state_d = PS_SELFREF;
                        LVL_S4:  state_d = PS_S4;
                        default: state_d = PS_S5;
                    endcase
                end else if (expired) begin
                    state_d = PS_S0;
                end
            end
            PS_SELFREF: begin
                if (mem_sr_done_i)  state_d = PS_S3;
                else if (expired)   state_d = PS_S0;
            end
            default: begin
                if (wake) state_d = PS_S0;
            end
        endcase
        if (btn_hold) state_d = PS_S5;
    end

    // State and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_S0;
            tgt_q   <= LVL_S0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // Sticky status bits; a clear wins over a same-cycle set.
    always_ff @(posedge clk) begin
        if (!rst_n || status_clr_i) begin
            btn_short_o <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            if (btn_short) btn_short_o <= 1'b1;
            if (abort)     err_o       <= 1'b1;
        end
    end

    // Output decode from the state register.
    always_comb begin
        cur_state_o   = lvl_of(state_q);
        clkstop_req_o = (state_q != PS_S0);
        mem_sr_req_o  = (state_q == PS_SELFREF) || (state_q == PS_S3);
        cpu_sleep_o   = (state_q == PS_S1);
        rail_s3_off_o = (state_q == PS_S3) || (state_q == PS_S4) || (state_q == PS_S5);
        rail_s4_off_o = (state_q == PS_S4) || (state_q == PS_S5);
        plat_rst_o    = (state_q == PS_S1) || rail_s3_off_o;
    end

endmodule

// File: rtl/pwr_state_seq_chk.sv
// Protocol checker for the sleep-state sequencer, bound to the top module.
// Assumes: observes only top-level ports.
module pwr_state_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       status_clr_i,
    input logic       clkstop_ack_i,
    input logic       mem_sr_done_i,
    input logic       clkstop_req_o,
    input logic       mem_sr_req_o,
    input logic       cpu_sleep_o,
    input logic       rail_s3_off_o,
    input logic       rail_s4_off_o,
    input logic       plat_rst_o,
    input logic [2:0] cur_state_o,
    input logic       err_o
);
    assert_no_s2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state_o inside {3'd0, 3'd1, 3'd3, 3'd4, 3'd5});

    assert_sleep_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_sleep_o) |-> $past(clkstop_ack_i));

    assert_clkstop_while_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        plat_rst_o |-> clkstop_req_o);

    assert_selfref_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_sr_req_o) |-> ($past(clkstop_ack_i) && $past(clkstop_req_o)));

    assert_rails_after_selfref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rail_s3_off_o) && !rail_s4_off_o) |-> ($past(mem_sr_done_i) && $past(mem_sr_req_o)));

    assert_reset_in_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sleep_o || rail_s3_off_o) |-> plat_rst_o);

    assert_s1_rails_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_sleep_o |-> (!rail_s3_off_o && !rail_s4_off_o));

    assert_s4_rails_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rail_s4_off_o |-> (rail_s3_off_o && cur_state_o inside {3'd4, 3'd5}));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !status_clr_i) |=> err_o);

endmodule

bind pwr_state_seq pwr_state_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .status_clr_i  (status_clr_i),
    .clkstop_ack_i (clkstop_ack_i),
    .mem_sr_done_i (mem_sr_done_i),
    .clkstop_req_o (clkstop_req_o),
    .mem_sr_req_o  (mem_sr_req_o),
    .cpu_sleep_o   (cpu_sleep_o),
    .rail_s3_off_o (rail_s3_off_o),
    .rail_s4_off_o (rail_s4_off_o),
    .plat_rst_o    (plat_rst_o),
    .cur_state_o   (cur_state_o),
    .err_o         (err_o)
);

// File: tb/pwr_state_seq_tb_top.sv
// Self-checking bench: sweeps request codes, level/wake-source pairs,
// the S3 ordering, button override, short press and handshake timeouts.
module pwr_state_seq_tb_top;
    localparam int DEB  = 4;
    localparam int HOLD = 48;
    localparam int LIM  = 100;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       sw_req_valid = 1'b0;
    logic [2:0] sw_req_state = 3'd0;
    logic       status_clr = 1'b0;
    logic       btn_n = 1'b1;
    logic       ack = 1'b0;
    logic       sr_done = 1'b0;
    logic       pme = 1'b0, pcie = 1'b0, usb = 1'b0, ps2 = 1'b0, lan = 1'b0;
    logic       clkstop_req, mem_sr_req, cpu_sleep, rail3, rail4, plat_rst;
    logic [2:0] cur_state;
    logic       btn_short, err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    pwr_state_seq #(.DEB_CYC(DEB), .HOLD_CYC(HOLD), .ACK_LIMIT(LIM)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sw_req_valid_i (sw_req_valid),
        .sw_req_state_i (sw_req_state),
        .status_clr_i   (status_clr),
        .pwr_btn_n_i    (btn_n),
        .clkstop_ack_i  (ack),
        .mem_sr_done_i  (sr_done),
        .wake_pme_i     (pme),
        .wake_pcie_i    (pcie),
        .wake_usb_i     (usb),
        .wake_ps2_i     (ps2),
        .wake_lan_i     (lan),
        .clkstop_req_o  (clkstop_req),
        .mem_sr_req_o   (mem_sr_req),
        .cpu_sleep_o    (cpu_sleep),
        .rail_s3_off_o  (rail3),
        .rail_s4_off_o  (rail4),
        .plat_rst_o     (plat_rst),
        .cur_state_o    (cur_state),
        .btn_short_o    (btn_short),
        .err_o          (err)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outputs of a settled level, derived from the requirements.
    task automatic chk_level(string tag, int lvl);
        chk({tag, " level"},     int'(cur_state),   lvl);
        chk({tag, " clkstop"},   int'(clkstop_req), int'(lvl != 0));
        chk({tag, " selfref"},   int'(mem_sr_req),  int'(lvl == 3));
        chk({tag, " cpu_sleep"}, int'(cpu_sleep),   int'(lvl == 1));
        chk({tag, " rail3"},     int'(rail3),       int'(lvl >= 3));
        chk({tag, " rail4"},     int'(rail4),       int'(lvl >= 4));
        chk({tag, " reset"},     int'(plat_rst),    int'(lvl != 0));
    endtask

    task automatic request(int lvl);
        sw_req_valid = 1'b1;
        sw_req_state = 3'(lvl);
        tick();
        sw_req_valid = 1'b0;
    endtask

    task automatic enter(int lvl);
        request(lvl);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        if (lvl == 3) begin
            sr_done = 1'b1;
            tick();
            sr_done = 1'b0;
        end
    endtask

    task automatic press(int held);
        btn_n = 1'b0;
        tick(held);
        btn_n = 1'b1;
        tick(12);
    endtask

    task automatic clear_status();
        status_clr = 1'b1;
        tick();
        status_clr = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        chk_level("R1 reset", 0);
        chk("R1 short status", int'(btn_short), 0);
        chk("R1 err status", int'(err), 0);

        // Sweep every request code from S0.
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 3 || c == 4 || c == 5) begin
                enter(c);
                if (c == 1)      chk_level("R6 entered", c);
                else if (c == 3) chk_level("R5 entered", c);
                else             chk_level("R7 entered", c);
                press(12);
                chk("R9 button wake", int'(cur_state), 0);
                chk("R9 awake reset", int'(plat_rst), 0);
                clear_status();
            end else begin
                request(c);
                tick(3);
                chk("R2 rejected level", int'(cur_state), 0);
                chk("R2 no clock stop", int'(clkstop_req), 0);
            end
        end

        // S3 ordering step by step.
        request(3);
        chk("R3 clkstop first", int'(clkstop_req), 1);
        chk("R3 no selfref yet", int'(mem_sr_req), 0);
        tick(5);
        chk("R3 waits for grant", int'(mem_sr_req), 0);
        chk("R3 no reset yet", int'(plat_rst), 0);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        chk("R4 selfref after grant", int'(mem_sr_req), 1);
        chk("R4 rails on", int'(rail3), 0);
        tick(5);
        chk("R4 rails wait for done", int'(rail3), 0);
        sr_done = 1'b1;
        tick();
        sr_done = 1'b0;
        chk_level("R5 after done", 3);
        press(12);
        clear_status();

        // Wake-source sweep over all sleep levels.
        for (int li = 0; li < 4; li++) begin
            for (int src = 0; src < 5; src++) begin
                int lvl;
                int exp;
                lvl = (li == 0) ? 1 : (li == 1) ? 3 : (li == 2) ? 4 : 5;
                exp = (src < 2 && lvl <= 3) ? 0 : lvl;
                enter(lvl);
                case (src)
                    0: pme  = 1'b1;
                    1: pcie = 1'b1;
                    2: usb  = 1'b1;
                    3: ps2  = 1'b1;
                    default: lan = 1'b1;
                endcase
                tick();
                {pme, pcie, usb, ps2, lan} = '0;
                tick(2);
                if (lvl == 1) chk("R8 wake source in S1", int'(cur_state), exp);
                else          chk("R9 wake source", int'(cur_state), exp);
                if (cur_state != 3'd0) press(12);
                clear_status();
            end
        end

        // Software requests ignored outside S0.
        enter(1);
        request(3);
        tick(3);
        chk("R13 request ignored", int'(cur_state), 1);
        chk("R13 no selfref", int'(mem_sr_req), 0);
        pme = 1'b1;
        tick();
        pme = 1'b0;
        chk("R8 pme wake", int'(cur_state), 0);

        // Short press in S0.
        press(12);
        chk("R11 short press sets status", int'(btn_short), 1);
        chk("R11 no state change", int'(cur_state), 0);
        clear_status();
        chk("R11 status cleared", int'(btn_short), 0);

        // Override from S3: wake first, then forced S5.
        enter(3);
        btn_n = 1'b0;
        tick(40);
        chk("R10 woken before override", int'(cur_state), 0);
        tick(50);
        chk_level("R10 override", 5);
        btn_n = 1'b1;
        tick(12);
        chk("R11 long press no status", int'(btn_short), 0);
        chk("R10 stays off after release", int'(cur_state), 5);
        press(12);
        chk("R9 wake from override", int'(cur_state), 0);
        clear_status();

        // Override in the middle of an entry sequence.
        request(1);
        btn_n = 1'b0;
        tick(30);
        chk("R10 still entering", int'(clkstop_req), 1);
        chk("R10 not yet off", int'(cur_state), 0);
        tick(50);
        chk_level("R10 override mid entry", 5);
        chk("R10 no error", int'(err), 0);
        btn_n = 1'b1;
        tick(12);
        press(12);
        clear_status();

        // Timeout waiting for the clock-stop grant.
        request(4);
        tick(94);
        chk("R12 still waiting", int'(clkstop_req), 1);
        chk("R12 no error yet", int'(err), 0);
        tick(10);
        chk_level("R12 grant timeout", 0);
        chk("R12 error set", int'(err), 1);
        tick(3);
        chk("R12 error sticky", int'(err), 1);
        clear_status();
        chk("R12 error cleared", int'(err), 0);

        // Timeout waiting for self-refresh.
        request(3);
        ack = 1'b1;
        tick();
        ack = 1'b0;
        tick(94);
        chk("R12 selfref waiting", int'(mem_sr_req), 1);
        tick(10);
        chk_level("R12 selfref timeout", 0);
        chk("R12 selfref error", int'(err), 1);
        clear_status();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule